// File: doc/BRIEF.md
# Signaling Change Interrupt Aggregator

This block collects per-channel signaling change pulses from a receive signaling store covering a set of trunk channels (24 by default). Each qualified pulse sets a sticky change flag for its channel, and the host reads these flags to learn which channels changed. A channel configured as a clear (data-only) channel is masked out, so its pulses never set a flag and never start a timer.

Interrupts are coalesced. The first qualified change seen while the block is idle starts a holdoff window of 1, 4 or 8 millisecond ticks, and the length is chosen by a two-bit select. Changes that arrive while the window is running are recorded but do not restart it. When the window ends, one pending status bit is set. The interrupt line carries that status whenever the active-high mask input is low. A single host clear pulse empties the status and the flags together. A change that lands in the same cycle as the clear is kept, and it opens the next window.

Top module: `sig_chg_irq_agg`

## Requirements
- R1: A pulse on `chg_pulse[i]` with `clear_chan[i]` low sets `chg_flags[i]` on the next clock edge.
- R2: A pulse on a channel whose `clear_chan` bit is high sets no flag and starts no holdoff window.
- R3: A holdoff window starts on the edge where a qualified change is seen while idle. `stat_pend` sets on the edge of the Nth `ms_tick` after that, where N is 1 for `tmr_sel`=0, 4 for 1, and 8 for 2 or 3. A tick in the starting cycle is not counted.
- R4: Changes during a running window do not restart it, so any number of changes inside one window produce a single pending event.
- R5: The window length is taken from `tmr_sel` when the window starts. Later changes to `tmr_sel` do not alter a running window.
- R6: `irq` is high exactly when `stat_pend` is high and `irq_mask` is low. With the mask high, `stat_pend` still sets.
- R7: A `rd_clr` pulse clears `stat_pend` and all flags on the next edge. A qualified change in that same cycle leaves its flag set and, if the block is idle, starts a new window.
- R8: Once set, `stat_pend` and `irq` stay high until `rd_clr`, however many ticks follow.
- R9: After reset, `irq`, `stat_pend` and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chg_pulse | input | NUM_CH | One-cycle signaling change pulse per channel |
| clear_chan | input | NUM_CH | Per-channel clear-channel bit, high excludes the channel |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tmr_sel | input | 2 | Holdoff select: 0 = 1 tick, 1 = 4 ticks, 2 or 3 = 8 ticks |
| irq_mask | input | 1 | Interrupt mask, high blocks `irq` |
| rd_clr | input | 1 | Host read-and-clear pulse for status and flags |
| irq | output | 1 | Masked interrupt |
| stat_pend | output | 1 | Pending interrupt status |
| chg_flags | output | NUM_CH | Sticky per-channel change flags |

## Verification
The bench builds the block with its defaults: 24 channels and holdoff lengths of 1, 4 and 8 ticks. It drives `ms_tick` every few clocks, which keeps even the 8-tick window short. With these values it can reach the exact expiry edge for every select value, and it can change the select in the middle of a window. It also covers the collision of a host clear with a new change, and a clear-channel pulse on the highest channel index.

// File: rtl/sig_chg_pkg.sv
package sig_chg_pkg;
  typedef enum logic {
    HO_IDLE = 1'b0,
    HO_RUN  = 1'b1
  } ho_state_e;
endpackage

// File: rtl/sig_chg_rst_sync.sv
module sig_chg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/sig_chg_flags.sv
module sig_chg_flags #(
  parameter int NUM_CH = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chg_pulse,
  input  logic [NUM_CH-1:0] clear_chan,
  input  logic              rd_clr,
  output logic [NUM_CH-1:0] flags,
  output logic              any_qual
);
  logic [NUM_CH-1:0] qual;

  assign qual     = chg_pulse & ~clear_chan;
  assign any_qual = |qual;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic flag_d, flag_q;
    logic flag_en;

    assign flag_en = rd_clr | qual[i];

    always_comb begin
      flag_d = flag_q;
      if (rd_clr)  flag_d = 1'b0;
      if (qual[i]) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags[i] = flag_q;

    // R1: a qualified pulse sets the flag
    a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_pulse[i] && !clear_chan[i]) |=> flags[i]);
    // R2: a clear-channel pulse sets nothing
    a_r2_clear_chan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && chg_pulse[i] && clear_chan[i]) |=> !flags[i]);
    // R7: flags only drop on a host clear
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !rd_clr) |=> flags[i]);
  end
endmodule

// File: rtl/sig_chg_holdoff.sv
module sig_chg_holdoff
  import sig_chg_pkg::*;
#(
  parameter int LIM_SHORT = 1,
  parameter int LIM_MID   = 4,
  parameter int LIM_LONG  = 8,
  parameter int CNT_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ms_tick,
  input  logic [1:0] tmr_sel,
  input  logic       rd_clr,
  output logic       pend
);
  ho_state_e  st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] sel_lim;
  logic pend_q, pend_d;
  logic expire;
  logic last_tick;

  always_comb begin
    case (tmr_sel)
      2'd0:    sel_lim = CNT_W'(LIM_SHORT);
      2'd1:    sel_lim = CNT_W'(LIM_MID);
      default: sel_lim = CNT_W'(LIM_LONG);
    endcase
  end

  assign last_tick = (cnt_q + CNT_W'(1)) == lim_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    expire = 1'b0;
    case (st_q)
      HO_IDLE: begin
        if (start) begin
          st_d  = HO_RUN;
          cnt_d = '0;
          lim_d = sel_lim;
        end
      end
      HO_RUN: begin
        if (ms_tick) begin
          if (last_tick) begin
            expire = 1'b1;
            st_d   = HO_IDLE;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: st_d = HO_IDLE;
    endcase
    pend_d = pend_q;
    if (rd_clr) pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HO_IDLE;
      cnt_q  <= '0;
      lim_q  <= CNT_W'(1);
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3: status only rises on a millisecond tick
  a_r3_pend_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(ms_tick));
  // R4: a running window is not restarted by further changes
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HO_RUN && !ms_tick) |=> (st_q == HO_RUN && $stable(cnt_q)));
  // R5: the latched length stays fixed while running
  a_r5_lim_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HO_RUN && !(ms_tick && last_tick)) |=> $stable(lim_q));
  // R8: status persists until a host clear
  a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_clr) |=> pend_q);
endmodule

// File: rtl/sig_chg_irq_agg.sv
module sig_chg_irq_agg #(
  parameter int NUM_CH    = 24,
  parameter int LIM_SHORT = 1,
  parameter int LIM_MID   = 4,
  parameter int LIM_LONG  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chg_pulse,
  input  logic [NUM_CH-1:0] clear_chan,
  input  logic              ms_tick,
  input  logic [1:0]        tmr_sel,
  input  logic              irq_mask,
  input  logic              rd_clr,
  output logic              irq,
  output logic              stat_pend,
  output logic [NUM_CH-1:0] chg_flags
);
  localparam int LIM_MAX = (LIM_LONG > LIM_MID) ?
                           ((LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT) :
                           ((LIM_MID > LIM_SHORT) ? LIM_MID : LIM_SHORT);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic rst_n_i;
  logic any_qual;
  logic pend;

  sig_chg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sig_chg_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .chg_pulse  (chg_pulse),
    .clear_chan (clear_chan),
    .rd_clr     (rd_clr),
    .flags      (chg_flags),
    .any_qual   (any_qual)
  );

  sig_chg_holdoff #(
    .LIM_SHORT (LIM_SHORT),
    .LIM_MID   (LIM_MID),
    .LIM_LONG  (LIM_LONG),
    .CNT_W     (CNT_W)
  ) u_holdoff (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start   (any_qual),
    .ms_tick (ms_tick),
    .tmr_sel (tmr_sel),
    .rd_clr  (rd_clr),
    .pend    (pend)
  );

  assign stat_pend = pend;
  assign irq       = pend & ~irq_mask;

  // R8: a set status is not lost while no clear arrives
  a_r8_irq_persists: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq && !rd_clr && !irq_mask) |=> stat_pend);
endmodule

// File: tb/sig_chg_irq_agg_bench.sv
module sig_chg_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] chg_pulse, clear_chan, chg_flags;
  logic ms_tick, irq_mask, rd_clr, irq, stat_pend;
  logic [1:0] tmr_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_chg_irq_agg u_sig_chg_irq_agg (
    .clk(clk), .rst_n(rst_n), .chg_pulse(chg_pulse), .clear_chan(clear_chan),
    .ms_tick(ms_tick), .tmr_sel(tmr_sel), .irq_mask(irq_mask), .rd_clr(rd_clr),
    .irq(irq), .stat_pend(stat_pend), .chg_flags(chg_flags)
  );

  // behavioural reference
  int sync_cnt;
  bit [NCH-1:0] m_flags;
  bit m_run, m_pend;
  int m_cnt, m_lim;

  function automatic int lim_of(logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 4;
    return 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt = 0; m_flags = '0; m_run = 0; m_pend = 0; m_cnt = 0; m_lim = 1;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      bit [NCH-1:0] q;
      bit fire;
      q = chg_pulse & ~clear_chan;
      fire = 0;
      if (rd_clr) m_flags = '0;
      m_flags |= q;
      if (m_run) begin
        if (ms_tick) begin
          if (m_cnt == m_lim - 1) begin fire = 1; m_run = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end else if (q != '0) begin
        m_run = 1; m_cnt = 0; m_lim = lim_of(tmr_sel);
      end
      if (rd_clr) m_pend = 0;
      if (fire) m_pend = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("R1 model flags", 32'(chg_flags), 32'(m_flags));
      chk("R3 model status", 32'(stat_pend), 32'(m_pend));
      chk("R6 model irq", 32'(irq), 32'(m_pend & ~irq_mask));
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk); #2;
  endtask

  task automatic pulse(logic [NCH-1:0] m);
    chg_pulse = m; cyc(); chg_pulse = '0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      repeat (2) cyc();
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
    end
  endtask

  task automatic clr();
    rd_clr = 1'b1; cyc(); rd_clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; chg_pulse = '0; clear_chan = '0; ms_tick = 1'b0;
    tmr_sel = 2'd0; irq_mask = 1'b0; rd_clr = 1'b0;
    repeat (3) cyc();
    // R9 reset state
    chk("R9 flags", 32'(chg_flags), 0);
    chk("R9 status", 32'(stat_pend), 0);
    chk("R9 irq", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 and R3 with 1-tick window; a tick in the start cycle is not counted
    ms_tick = 1'b1; pulse(NCH'(1) << 3); ms_tick = 1'b0;
    chk("R1 flag3", 32'(chg_flags), 32'h8);
    chk("R3 no pend on start tick", 32'(stat_pend), 0);
    ticks(1);
    chk("R3 pend after 1 tick", 32'(stat_pend), 1);
    chk("R6 irq unmasked", 32'(irq), 1);
    ticks(3);
    chk("R8 pend holds", 32'(irq), 1);
    clr();
    chk("R7 flags cleared", 32'(chg_flags), 0);
    chk("R7 status cleared", 32'(stat_pend), 0);

    // R2 clear-channel excluded, including the top channel
    clear_chan = (NCH'(1) << 5) | (NCH'(1) << (NCH-1));
    pulse(clear_chan);
    ticks(2);
    chk("R2 no flag", 32'(chg_flags), 0);
    chk("R2 no pend", 32'(stat_pend), 0);
    clear_chan = '0;

    // R4 several changes in a 4-tick window give one event
    tmr_sel = 2'd1;
    pulse(NCH'(1) << 1);
    ticks(2);
    pulse(NCH'(1) << 7);
    pulse(NCH'(1) << 9);
    ticks(1);
    chk("R4 no pend at tick 3", 32'(stat_pend), 0);
    ticks(1);
    chk("R4 pend at tick 4", 32'(stat_pend), 1);
    chk("R4 flags", 32'(chg_flags), 32'h282);
    clr();

    // R6 mask blocks irq but status sets
    irq_mask = 1'b1; tmr_sel = 2'd0;
    pulse(NCH'(1) << 20);
    ticks(1);
    chk("R6 status masked", 32'(stat_pend), 1);
    chk("R6 irq masked", 32'(irq), 0);
    irq_mask = 1'b0; cyc();
    chk("R6 irq after unmask", 32'(irq), 1);
    clr();

    // R5 select latched at window start (8 ticks)
    tmr_sel = 2'd2;
    pulse(NCH'(1) << 0);
    tmr_sel = 2'd0;
    ticks(7);
    chk("R5 no pend at tick 7", 32'(stat_pend), 0);
    ticks(1);
    chk("R5 pend at tick 8", 32'(stat_pend), 1);

    // R7 change in the clear cycle is kept and opens a new window
    rd_clr = 1'b1; chg_pulse = NCH'(1) << 10; cyc();
    rd_clr = 1'b0; chg_pulse = '0;
    chk("R7 collided flag kept", 32'(chg_flags), 32'h400);
    chk("R7 status cleared", 32'(stat_pend), 0);
    ticks(1);
    chk("R7 new window fires", 32'(stat_pend), 1);
    clr();

    // select 3 behaves as 8
    tmr_sel = 2'd3;
    pulse(NCH'(1) << 15);
    ticks(7);
    chk("R3 sel3 tick 7", 32'(stat_pend), 0);
    ticks(1);
    chk("R3 sel3 tick 8", 32'(stat_pend), 1);
    repeat (3) cyc();
    finish_run();
  end
endmodule